// File: doc/BRIEF.md
# PLL Speed-Up Window Timer

This block decides when a synthesizer's charge pump should run in its wide-bandwidth speed-up condition after the main loop's frequency word has been rewritten. While the window is open it holds two enables high. One raises the proportional pump current. The other switches the integral pump current on. The block runs on the reference-input clock. A separate configuration load captures a 4-bit duration code G, the reference divide ratio NR and a prescale factor SM. A pulse on `main_load` marks each write of the main divider word.

There are two timing modes, and the mode is sampled on each main-word write. In the counted mode the window lasts a number of reference cycles that is computed from G, NR and SM. The top code of G selects a very short window, shorter than half a phase-detector period. In the strobe-following mode the main-word write only arms the block. The window then opens when the external strobe is seen high and closes when the strobe is seen low.

The controller is a four-state machine:
- **S_IDLE**: no window.
- **S_COUNT**: timed window.
- **S_ARMED**: a write was seen in strobe mode, and the strobe has not yet been seen high.
- **S_FOLLOW**: window held open by the strobe.

The transitions are:
- **idle→count** and **idle→armed**: a write, with the mode deciding which.
- **count→count**: a restart on a new counted-mode write.
- **count→idle**: the terminal count is reached.
- **count→armed**: a strobe-mode write.
- **armed→follow**: the strobe is seen high.
- **armed→count**: a counted-mode write.
- **follow→idle**: the strobe is seen low.
- **follow→count**: a counted-mode write.
- **follow→armed**: a strobe-mode write while the strobe is low.

Top module: `pll_speedup_timer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) returns the block to S_IDLE with both enables low. It also sets the stored configuration to G=0, NR=1, SM=1.
- R2: `cfg_load` captures `cfg_g`, `cfg_nr` and `cfg_sm`. A configuration load by itself never raises either enable.
- R3: In counted mode (`mode_emul`=0) with G from 0 to 14, a main-word write sampled at clock edge k holds the enables high from edge k until edge k+D, where D = (G+1)·NR·SM·16 cycles.
- R4: In counted mode with G=15, D = floor(NR·SM/2) − 1 cycles, with a minimum of 1.
- R5: If the product NR·SM is zero, the counted window lasts exactly 1 cycle.
- R6: A counted-mode write that arrives during an open counted window restarts the count. The window then ends D cycles after the new write edge.
- R7: Configuration loads during an open counted window do not change that window's length. The length is fixed at the write.
- R8: In strobe mode (`mode_emul`=1) a write arms the block. The enables rise at the first edge that samples `strobe` high while armed. They fall at the first edge that samples `strobe` low. A strobe held high for n edges therefore gives n cycles of window.
- R9: A strobe while the block is not armed (idle, or after a window has closed) leaves both enables low.
- R10: The two enables `su_prop_hi` and `su_int_on` are always equal.
- R11: The mode is taken at the write edge. Changing `mode_emul` during an open counted window does not alter it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-input clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | One-cycle pulse that captures G, NR and SM |
| cfg_g | input | G_W (4) | Duration code G |
| cfg_nr | input | NR_W (16) | Reference divide ratio NR |
| cfg_sm | input | SM_W (4) | Prescale factor SM |
| main_load | input | 1 | One-cycle pulse marking a main-word write |
| mode_emul | input | 1 | 0 = counted mode, 1 = strobe-following mode |
| strobe | input | 1 | External strobe used in strobe mode |
| su_prop_hi | output | 1 | Raise proportional pump current |
| su_int_on | output | 1 | Enable integral pump current |

## Verification
The bench sweeps every G code over several NR and SM values. It compares each window length with the closed-form duration, so a design that is off by one in the terminal count, or that drops the ×16 factor, shows up as a wrong cycle count. The G=15 code is swept over all small NR·SM products, including products below 4 where the minimum of one cycle applies. A design that misses that clamp would produce a zero-length or wrapped window. The restart, mid-window configuration and mode changes target a design that keeps counting from the old start, or that reads the live configuration instead of the value latched at the write. Strobe windows of several lengths, and strobes that arrive without arming, expose a design that opens on any strobe or holds the window one cycle too long.

// File: rtl/su_timer_pkg.sv
package su_timer_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_COUNT  = 2'd1,
        S_ARMED  = 2'd2,
        S_FOLLOW = 2'd3
    } su_state_e;

endpackage

// File: rtl/su_cfg_reg.sv
module su_cfg_reg #(
    parameter int G_W  = 4,
    parameter int NR_W = 16,
    parameter int SM_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [G_W-1:0]  g_d,
    input  logic [NR_W-1:0] nr_d,
    input  logic [SM_W-1:0] sm_d,
    output logic [G_W-1:0]  g_q,
    output logic [NR_W-1:0] nr_q,
    output logic [SM_W-1:0] sm_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q  <= '0;
            nr_q <= NR_W'(1);
            sm_q <= SM_W'(1);
        end else if (load) begin
            g_q  <= g_d;
            nr_q <= nr_d;
            sm_q <= sm_d;
        end
    end

    // R1: configuration defaults are present right after reset
    a_r1_cfg_default: assert property (@(posedge clk)
        $past(rst) |-> (g_q == '0 && nr_q == NR_W'(1) && sm_q == SM_W'(1)));

endmodule

// File: rtl/su_limit_calc.sv
module su_limit_calc #(
    parameter int G_W   = 4,
    parameter int NR_W  = 16,
    parameter int SM_W  = 4,
    parameter int CNT_W = G_W + 1 + NR_W + SM_W + 4
) (
    input  logic [G_W-1:0]   g,
    input  logic [NR_W-1:0]  nr,
    input  logic [SM_W-1:0]  sm,
    output logic [CNT_W-1:0] limit
);

    localparam int PROD_W  = NR_W + SM_W;
    localparam int SCALE_SH = 4;
    localparam logic [G_W-1:0] G_SHORT = {G_W{1'b1}};

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] half;
    logic [CNT_W-1:0]  mult;
    logic [CNT_W-1:0]  long_d;
    logic [CNT_W-1:0]  short_d;

    always_comb begin
        prod    = PROD_W'(nr) * PROD_W'(sm);
        half    = prod >> 1;
        mult    = CNT_W'(g) + CNT_W'(1);
        long_d  = (mult * CNT_W'(prod)) << SCALE_SH;
        short_d = (half > PROD_W'(1)) ? CNT_W'(half - PROD_W'(1)) : CNT_W'(1);
        if (g == G_SHORT) begin
            limit = short_d;
        end else if (long_d == '0) begin
            limit = CNT_W'(1);
        end else begin
            limit = long_d;
        end
    end

    // R5: a window is never zero cycles long
    always_comb begin
        a_r5_limit_nonzero: assert (limit != '0);
    end

endmodule

// File: rtl/su_tick_counter.sv
module su_tick_counter #(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             last
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (run) begin
            count <= count + CNT_W'(1);
        end
    end

    assign last = (count == limit - CNT_W'(1));

    // R3: the counter advances by exactly one per running cycle
    a_r3_step_one: assert property (@(posedge clk) disable iff (rst)
        (run && !clear) |=> count == $past(count) + CNT_W'(1));

    // R6: a clear returns the count to zero
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clear |=> count == '0);

endmodule

// File: rtl/pll_speedup_timer.sv
module pll_speedup_timer
    import su_timer_pkg::*;
#(
    parameter int G_W  = 4,
    parameter int NR_W = 16,
    parameter int SM_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_load,
    input  logic [G_W-1:0]  cfg_g,
    input  logic [NR_W-1:0] cfg_nr,
    input  logic [SM_W-1:0] cfg_sm,
    input  logic            main_load,
    input  logic            mode_emul,
    input  logic            strobe,
    output logic            su_prop_hi,
    output logic            su_int_on
);

    localparam int CNT_W = G_W + 1 + NR_W + SM_W + 4;

    su_state_e state;
    su_state_e nxt;

    logic [G_W-1:0]   g_q;
    logic [NR_W-1:0]  nr_q;
    logic [SM_W-1:0]  sm_q;
    logic [CNT_W-1:0] lim_d;
    logic [CNT_W-1:0] lim_q;
    logic [CNT_W-1:0] cnt;
    logic             cnt_last;
    logic             cnt_run;

    su_cfg_reg #(.G_W(G_W), .NR_W(NR_W), .SM_W(SM_W)) u_cfg (
        .clk  (clk),
        .rst  (rst),
        .load (cfg_load),
        .g_d  (cfg_g),
        .nr_d (cfg_nr),
        .sm_d (cfg_sm),
        .g_q  (g_q),
        .nr_q (nr_q),
        .sm_q (sm_q)
    );

    su_limit_calc #(.G_W(G_W), .NR_W(NR_W), .SM_W(SM_W), .CNT_W(CNT_W)) u_lim (
        .g     (g_q),
        .nr    (nr_q),
        .sm    (sm_q),
        .limit (lim_d)
    );

    // window length is frozen at the write edge
    always_ff @(posedge clk) begin
        if (rst) begin
            lim_q <= CNT_W'(1);
        end else if (main_load) begin
            lim_q <= lim_d;
        end
    end

    assign cnt_run = (state == S_COUNT) && !cnt_last;

    su_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (main_load),
        .run   (cnt_run),
        .limit (lim_q),
        .count (cnt),
        .last  (cnt_last)
    );

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (main_load) nxt = mode_emul ? S_ARMED : S_COUNT;
            end
            S_COUNT: begin
                if (main_load)     nxt = mode_emul ? S_ARMED : S_COUNT;
                else if (cnt_last) nxt = S_IDLE;
            end
            S_ARMED: begin
                if (main_load)   nxt = mode_emul ? S_ARMED : S_COUNT;
                else if (strobe) nxt = S_FOLLOW;
            end
            S_FOLLOW: begin
                if (main_load)    nxt = !mode_emul ? S_COUNT : (strobe ? S_FOLLOW : S_ARMED);
                else if (!strobe) nxt = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            su_prop_hi <= 1'b0;
            su_int_on  <= 1'b0;
        end else begin
            su_prop_hi <= (nxt == S_COUNT) || (nxt == S_FOLLOW);
            su_int_on  <= (nxt == S_COUNT) || (nxt == S_FOLLOW);
        end
    end

    // R1: enables are low in the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!su_prop_hi && !su_int_on && state == S_IDLE));

    // R10: both enables agree
    a_r10_enables_match: assert property (@(posedge clk) disable iff (rst)
        su_prop_hi == su_int_on);

    // R3: the count stays below the latched limit while counting
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (state == S_COUNT) |-> cnt < lim_q);

    // R6: a counted-mode write always (re)starts a counted window
    a_r6_restart: assert property (@(posedge clk) disable iff (rst)
        (main_load && !mode_emul) |=> (state == S_COUNT && cnt == '0 && su_prop_hi));

    // R9: with no write, an idle block stays idle whatever the strobe does
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && !main_load) |=> (state == S_IDLE && !su_prop_hi));

    // R8: a strobe seen low while following closes the window
    a_r8_strobe_close: assert property (@(posedge clk) disable iff (rst)
        (state == S_FOLLOW && !strobe && !main_load) |=> !su_prop_hi);

    // R8: the window opens only from the armed state with the strobe high
    a_r8_open_from_arm: assert property (@(posedge clk) disable iff (rst)
        (state == S_ARMED && strobe && !main_load) |=> (state == S_FOLLOW && su_prop_hi));

endmodule

// File: tb/test_pll_speedup_timer.sv
`timescale 1ns/1ps
module test_pll_speedup_timer;

    localparam int G_W  = 4;
    localparam int NR_W = 4;
    localparam int SM_W = 3;
    localparam int MAXW = 40000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_load = 1'b0;
    logic [G_W-1:0]  cfg_g = '0;
    logic [NR_W-1:0] cfg_nr = '0;
    logic [SM_W-1:0] cfg_sm = '0;
    logic            main_load = 1'b0;
    logic            mode_emul = 1'b0;
    logic            strobe = 1'b0;
    logic            su_prop_hi;
    logic            su_int_on;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    pll_speedup_timer #(.G_W(G_W), .NR_W(NR_W), .SM_W(SM_W)) i_pll_speedup_timer (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_g(cfg_g), .cfg_nr(cfg_nr),
        .cfg_sm(cfg_sm), .main_load(main_load), .mode_emul(mode_emul), .strobe(strobe),
        .su_prop_hi(su_prop_hi), .su_int_on(su_int_on)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_dur(input int g, input int nr, input int sm);
        int p;
        int h;
        int d;
        p = nr * sm;
        if (g == 15) begin
            h = p / 2;
            return (h > 1) ? h - 1 : 1;
        end
        d = (g + 1) * p * 16;
        return (d == 0) ? 1 : d;
    endfunction

    task automatic set_cfg(input int g, input int nr, input int sm);
        @(negedge clk);
        cfg_g = G_W'(g); cfg_nr = NR_W'(nr); cfg_sm = SM_W'(sm); cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // counts high samples from the current negedge onward; leaves at the first low sample
    task automatic count_rest(inout int hi);
        while (su_prop_hi && hi < MAXW) begin
            if (su_int_on != su_prop_hi) check(1'b0, "R10 enables differ", su_int_on, su_prop_hi);
            hi++;
            @(negedge clk);
        end
    endtask

    task automatic window(output int hi);
        @(negedge clk);
        main_load = 1'b1;
        @(negedge clk);
        main_load = 1'b0;
        hi = 0;
        count_rest(hi);
    endtask

    initial begin
        repeat (20 * 190000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int hi;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!su_prop_hi && !su_int_on, "R1 outputs after reset", su_prop_hi, 0);
        // R1 default cfg G=0 NR=1 SM=1 gives 16 cycles
        window(hi);
        check(hi == 16, "R1 default configuration window", hi, 16);

        // R2 config load alone raises nothing
        set_cfg(2, 3, 1);
        repeat (3) @(negedge clk);
        check(!su_prop_hi && !su_int_on, "R2 cfg load without write", su_prop_hi, 0);

        // R3 sweep of all G codes over small NR, SM
        for (int nr = 1; nr <= 3; nr++) begin
            for (int sm = 1; sm <= 2; sm++) begin
                for (int g = 0; g <= 14; g++) begin
                    set_cfg(g, nr, sm);
                    window(hi);
                    check(hi == exp_dur(g, nr, sm), "R3 counted window length", hi, exp_dur(g, nr, sm));
                end
            end
        end

        // R4 short code over every NR x SM product
        for (int nr = 0; nr <= 15; nr++) begin
            for (int sm = 0; sm <= 7; sm++) begin
                set_cfg(15, nr, sm);
                window(hi);
                check(hi == exp_dur(15, nr, sm), "R4 short code window", hi, exp_dur(15, nr, sm));
            end
        end

        // R5 zero product with a long code
        set_cfg(3, 0, 5);
        window(hi);
        check(hi == 1, "R5 zero NR window", hi, 1);
        set_cfg(9, 7, 0);
        window(hi);
        check(hi == 1, "R5 zero SM window", hi, 1);

        // R6 restart: rewrite at the fifth cycle of the window
        set_cfg(0, 2, 1);
        @(negedge clk);
        main_load = 1'b1;
        @(negedge clk);
        main_load = 1'b0;
        hi = 0;
        repeat (4) begin
            if (su_prop_hi) hi++;
            @(negedge clk);
        end
        main_load = 1'b1;
        if (su_prop_hi) hi++;
        @(negedge clk);
        main_load = 1'b0;
        count_rest(hi);
        check(hi == 5 + 32, "R6 restart window length", hi, 37);

        // R7 and R11: cfg and mode changes mid-window leave the window alone
        set_cfg(0, 1, 1);
        @(negedge clk);
        main_load = 1'b1;
        @(negedge clk);
        main_load = 1'b0;
        cfg_g = 4'd5; cfg_nr = 4'd9; cfg_load = 1'b1;
        mode_emul = 1'b1;
        hi = 0;
        if (su_prop_hi) hi++;
        @(negedge clk);
        cfg_load = 1'b0;
        count_rest(hi);
        check(hi == 16, "R7 R11 mid-window changes", hi, 16);
        mode_emul = 1'b0;

        // R9 strobe with nothing armed
        @(negedge clk);
        strobe = 1'b1;
        repeat (4) @(negedge clk);
        check(!su_prop_hi, "R9 strobe while idle in counted mode", su_prop_hi, 0);
        strobe = 1'b0;
        mode_emul = 1'b1;
        @(negedge clk);
        strobe = 1'b1;
        repeat (4) @(negedge clk);
        check(!su_prop_hi, "R9 strobe while idle in strobe mode", su_prop_hi, 0);
        strobe = 1'b0;

        // R8 strobe windows of several lengths
        for (int n = 1; n <= 6; n++) begin
            @(negedge clk);
            main_load = 1'b1;
            @(negedge clk);
            main_load = 1'b0;
            repeat (2) @(negedge clk);
            check(!su_prop_hi, "R8 armed without strobe stays low", su_prop_hi, 0);
            strobe = 1'b1;
            @(negedge clk);
            hi = 0;
            for (int k = 1; k < n; k++) begin
                if (su_prop_hi) hi++;
                @(negedge clk);
            end
            if (su_prop_hi) hi++;
            strobe = 1'b0;
            @(negedge clk);
            count_rest(hi);
            check(hi == n, "R8 strobe window length", hi, n);
            // R9 after the window closed, a new strobe does nothing
            strobe = 1'b1;
            repeat (3) @(negedge clk);
            check(!su_prop_hi, "R9 strobe after window closed", su_prop_hi, 0);
            strobe = 1'b0;
        end
        mode_emul = 1'b0;

        // R1 reset in the middle of a window
        set_cfg(14, 3, 2);
        @(negedge clk);
        main_load = 1'b1;
        @(negedge clk);
        main_load = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!su_prop_hi && !su_int_on, "R1 reset clears window", su_prop_hi, 0);
        repeat (5) @(negedge clk);
        check(!su_prop_hi, "R1 stays idle after reset", su_prop_hi, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule